// File: doc/BRIEF.md
# Dual-Target Serial Control Port

This block shifts control words out of a sequencer to two peripheral devices that share one serial data wire. Each transfer goes to one of two targets. The first target latches a word on a strobe pulse. The second target is framed by an active-low enable and samples at half the rate of the serial clock.

The serial clock is the 13 MHz system clock passed through a glitch-free gate. The gate normally lets every beat through. It drops exactly one rising edge during the strobe period that closes a first-target word. All pin-facing signals are retimed on the falling edge of the system clock, so that data, strobe and enable change while the clock is low.

The sequencer offers a word, a bit count and a target select with a start request. It watches `busy_o` and the one-cycle `done_o` pulse. A start that arrives while a word is in flight is dropped. Cycle numbering below counts rising edges of `clk` from the first edge after reset is released, beginning at 0. Pin values are the values seen during the low half of the clock that follows an edge.

Top module: `tsp_dual_tx`

## Requirements
- R1: During and after reset, with no request, the pins read data 0, strobe 0 and enable-not 1, `busy_o` and `done_o` are 0, and `sclk_o` follows `clk`.
- R2: A word is sent most significant bit first, using the `n` least significant bits of `word_i`. For target 0 (`tgt_i`=0), bit i (0 = first) appears after accept edge +i, one clock per bit, and changes on a falling edge.
- R3: For target 0, `strobe_o` is high for exactly one clock period, in the cycle after the last bit.
- R4: `sclk_o` is low whenever `clk` is low. It is high in every high phase except the single rising edge that falls inside the strobe period, which is suppressed.
- R5: For target 1 (`tgt_i`=1), the first bit starts on an even-numbered edge. An accept on an odd edge waits one cycle with enable-not still high.
- R6: For target 1, each bit is held for two clock periods, and `ten_n_o` is low for exactly 2·n periods, covering the whole word.
- R7: `nbits_i` from 1 to 32 gives that many bits. A value of 0, or any value above 32, sends 32 bits.
- R8: `busy_o` is high from the accept edge until the completion edge. A `start_i` seen while busy is ignored, and a held start is accepted on the first edge after completion.
- R9: `done_o` is a single-cycle pulse on the completion edge. For target 0 that is one edge after the strobe begins. For target 1 it is the edge on which the enable is released.
- R10: The shared data line reads 0 whenever no bit is being presented: while idle, during the strobe and during the alignment wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13 MHz system clock |
| rst | input | 1 | synchronous active-high reset |
| start_i | input | 1 | request to send a word |
| tgt_i | input | 1 | 0 = strobe-latched target, 1 = enable-framed target |
| nbits_i | input | 6 | bit count (0 or >32 means 32) |
| word_i | input | 32 | word to send, right-aligned |
| sclk_o | output | 1 | gated serial clock |
| sdata_o | output | 1 | shared serial data |
| strobe_o | output | 1 | latch strobe for target 0 |
| ten_n_o | output | 1 | active-low enable for target 1 |
| busy_o | output | 1 | transfer in flight |
| done_o | output | 1 | one-cycle completion pulse |

## Verification
A wrong bit counter or shift state shows on the data pin within one clock for target 0, and within two clocks for target 1. It also moves the strobe, the enable edge and the done pulse off their expected cycles. A phase error shows as an enable falling on an odd edge, or as a missing alignment cycle, in the first cycle of the word. A broken clock gate shows in the same high phase as either a missing beat outside the strobe or an extra beat inside it. A missed busy check shows as a word reloaded in mid-flight, which corrupts the very next data bit.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

    localparam int TSP_WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ABITS = 3'd1,
        ST_ASTB  = 3'd2,
        ST_BWAIT = 3'd3,
        ST_BBITS = 3'd4
    } tsp_state_t;

    typedef struct packed {
        logic data;
        logic stb;
        logic en;
        logic gate;
    } tsp_pins_t;

endpackage

// File: rtl/tsp_phase.sv
module tsp_phase (
    input  logic clk,
    input  logic rst,
    output logic ph_o
);
    always_ff @(posedge clk) begin
        if (rst) ph_o <= 1'b0;
        else     ph_o <= ~ph_o;
    end
endmodule

// File: rtl/tsp_shifter.sv
module tsp_shifter #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic [CNT_W-1:0]  len_i,
    output logic              msb_o
);
    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  shamt;

    assign shamt = CNT_W'(DATA_W) - len_i;
    assign msb_o = sh_q[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst)          sh_q <= '0;
        else if (load_i)  sh_q <= word_i << shamt;
        else if (shift_i) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
    end
endmodule

// File: rtl/tsp_ctrl.sv
module tsp_ctrl
    import tsp_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             tgt_i,
    input  logic [CNT_W-1:0] nbits_i,
    input  logic             ph_i,
    output logic             load_o,
    output logic             shift_o,
    output logic [CNT_W-1:0] len_o,
    output tsp_state_t       st_o,
    output logic             done_o
);
    tsp_state_t       st_q;
    logic [CNT_W-1:0] left_q;
    logic             half_q;
    logic             last_bit;

    assign len_o    = (nbits_i == '0 || nbits_i > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : nbits_i;
    assign load_o   = (st_q == ST_IDLE) && start_i;
    assign last_bit = (left_q == CNT_W'(1));
    assign st_o     = st_q;

    always_comb begin
        shift_o = 1'b0;
        if (st_q == ST_ABITS && !last_bit)          shift_o = 1'b1;
        if (st_q == ST_BBITS && half_q && !last_bit) shift_o = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            left_q <= '0;
            half_q <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (st_q)
                ST_IDLE: if (start_i) begin
                    left_q <= len_o;
                    half_q <= 1'b0;
                    if (!tgt_i)    st_q <= ST_ABITS;
                    else if (ph_i) st_q <= ST_BWAIT;
                    else           st_q <= ST_BBITS;
                end
                ST_ABITS: begin
                    if (last_bit) st_q <= ST_ASTB;
                    else          left_q <= left_q - CNT_W'(1);
                end
                ST_ASTB: begin
                    st_q   <= ST_IDLE;
                    done_o <= 1'b1;
                end
                ST_BWAIT: st_q <= ST_BBITS;
                ST_BBITS: begin
                    half_q <= ~half_q;
                    if (half_q) begin
                        if (last_bit) begin
                            st_q   <= ST_IDLE;
                            done_o <= 1'b1;
                        end else begin
                            left_q <= left_q - CNT_W'(1);
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R9
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ASTB) |=> (st_q != ST_ASTB)); // R3
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE) |-> (left_q >= CNT_W'(1) && left_q <= CNT_W'(DATA_W))); // R7
    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE && start_i) |-> !load_o); // R8
    AST_B_EVEN_START: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == ST_BBITS) |-> ($past(ph_i) == 1'b0)); // R5
endmodule

// File: rtl/tsp_pinstage.sv
module tsp_pinstage
    import tsp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tsp_pins_t core_i,
    output logic      sclk_o,
    output logic      sdata_o,
    output logic      strobe_o,
    output logic      ten_n_o
);
    tsp_pins_t neg_q;

    always_ff @(negedge clk) begin
        if (rst) neg_q <= '{data: 1'b0, stb: 1'b0, en: 1'b0, gate: 1'b1};
        else     neg_q <= core_i;
    end

    assign sclk_o   = clk & neg_q.gate;
    assign sdata_o  = neg_q.data;
    assign strobe_o = neg_q.stb;
    assign ten_n_o  = ~neg_q.en;
endmodule

// File: rtl/tsp_dual_tx.sv
module tsp_dual_tx
    import tsp_pkg::*;
#(
    parameter int DATA_W = TSP_WORD_W,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              tgt_i,
    input  logic [CNT_W-1:0]  nbits_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              sclk_o,
    output logic              sdata_o,
    output logic              strobe_o,
    output logic              ten_n_o,
    output logic              busy_o,
    output logic              done_o
);
    logic             ph_w, load_w, shift_w, msb_w;
    logic [CNT_W-1:0] len_w;
    tsp_state_t       st_w;
    tsp_pins_t        core_w;

    tsp_phase u_phase (.clk(clk), .rst(rst), .ph_o(ph_w));

    tsp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .tgt_i(tgt_i),
        .nbits_i(nbits_i), .ph_i(ph_w), .load_o(load_w), .shift_o(shift_w),
        .len_o(len_w), .st_o(st_w), .done_o(done_o)
    );

    tsp_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .load_i(load_w), .shift_i(shift_w),
        .word_i(word_i), .len_i(len_w), .msb_o(msb_w)
    );

    always_comb begin
        core_w.data = (st_w == ST_ABITS || st_w == ST_BBITS) ? msb_w : 1'b0;
        core_w.stb  = (st_w == ST_ASTB);
        core_w.en   = (st_w == ST_BBITS);
        core_w.gate = (st_w != ST_ASTB);
    end

    assign busy_o = (st_w != ST_IDLE);

    tsp_pinstage u_pins (
        .clk(clk), .rst(rst), .core_i(core_w), .sclk_o(sclk_o),
        .sdata_o(sdata_o), .strobe_o(strobe_o), .ten_n_o(ten_n_o)
    );

    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!core_w.en && !core_w.stb && !busy_o)); // R9
endmodule

// File: tb/tsp_dual_tx_tb.sv
`timescale 1ns/1ps
module tsp_dual_tx_tb_top;
    localparam int CLK_T = 76;
    localparam int Q = CLK_T / 4;

    // vector: {isbit, data, stb, ten_n, gate, busy, done}
    typedef logic [6:0] vec_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0, tgt_i = 1'b0;
    logic [5:0]  nbits_i = '0;
    logic [31:0] word_i = '0;
    logic sclk_o, sdata_o, strobe_o, ten_n_o, busy_o, done_o;

    int   total = 0, bad = 0, edge_n = 0;
    logic prev_gate = 1'b1;
    string tag = "R1";
    vec_t q[$];

    always #(CLK_T/2) clk = ~clk;

    tsp_dual_tx dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .tgt_i(tgt_i), .nbits_i(nbits_i),
        .word_i(word_i), .sclk_o(sclk_o), .sdata_o(sdata_o), .strobe_o(strobe_o),
        .ten_n_o(ten_n_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic vec_t mk(logic b, logic d, logic s, logic tn, logic g, logic bz, logic dn);
        return {b, d, s, tn, g, bz, dn};
    endfunction

    task automatic chk(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s [%s] edge=%0d actual=%0b expected=%0b", req, tag, edge_n, act, exp);
        end
    endtask

    task automatic push_word(logic [31:0] w, logic [5:0] nb, logic tg, logic odd);
        int n = (nb == 0 || nb > 32) ? 32 : int'(nb);
        if (!tg) begin
            for (int i = 0; i < n; i++) q.push_back(mk(1, w[n-1-i], 0, 1, 1, 1, 0));
            q.push_back(mk(0, 0, 1, 1, 0, 1, 0));
        end else begin
            if (odd) q.push_back(mk(0, 0, 0, 1, 1, 1, 0));
            for (int i = 0; i < n; i++) begin
                q.push_back(mk(1, w[n-1-i], 0, 0, 1, 1, 0));
                q.push_back(mk(1, w[n-1-i], 0, 0, 1, 1, 0));
            end
        end
        q.push_back(mk(0, 0, 0, 1, 1, 0, 1));
    endtask

    task automatic step(logic st, logic [31:0] w, logic [5:0] nb, logic tg);
        vec_t e;
        start_i = st; word_i = w; nbits_i = nb; tgt_i = tg;
        @(posedge clk);
        if (q.size() == 0 && st) push_word(w, nb, tg, edge_n[0]);
        e = (q.size() != 0) ? q.pop_front() : mk(0, 0, 0, 1, 1, 0, 0);
        #(Q);
        chk("R4", sclk_o, prev_gate);
        @(negedge clk);
        #(Q);
        chk("R4", sclk_o, 1'b0);
        chk(e[6] ? "R2" : "R10", sdata_o, e[5]);
        chk("R3", strobe_o, e[4]);
        chk("R6", ten_n_o, e[3]);
        chk("R8", busy_o, e[1]);
        chk("R9", done_o, e[0]);
        prev_gate = e[2];
        edge_n++;
        start_i = 1'b0;
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) step(0, 32'h0, 6'd0, 0);
    endtask

    task automatic send(logic [31:0] w, logic [5:0] nb, logic tg);
        step(1, w, nb, tg);
        while (q.size() != 0) step(0, 32'hFFFF_FFFF, 6'd3, ~tg);
        idle(2);
    endtask

    task automatic to_parity(logic par);
        while (edge_n[0] != par) idle(1);
    endtask

    initial begin
        #(CLK_T * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); #(Q);
        chk("R1", sdata_o, 1'b0);
        chk("R1", strobe_o, 1'b0);
        chk("R1", ten_n_o, 1'b1);
        chk("R1", busy_o, 1'b0);
        chk("R1", done_o, 1'b0);
        @(posedge clk); #(Q);
        chk("R1", sclk_o, 1'b1);
        @(negedge clk); #(Q);
        rst = 1'b0;
        tag = "R1"; idle(3);
        tag = "R2"; send(32'h0000_00A5, 6'd8, 0);
        tag = "R3"; send(32'h0000_0001, 6'd1, 0);
        tag = "R2"; send(32'hC3A5_96F1, 6'd32, 0);
        tag = "R5"; to_parity(0); send(32'h0000_0016, 6'd5, 1);
        tag = "R5"; to_parity(1); send(32'h0000_0019, 6'd5, 1);
        tag = "R6"; send(32'h8E31_7AC5, 6'd32, 1);
        tag = "R6"; to_parity(1); send(32'h0000_0001, 6'd1, 1);
        tag = "R7"; send(32'h9ABC_DEF0, 6'd0, 0);
        tag = "R7"; send(32'h1357_9BDF, 6'd40, 1);
        // R8: held start while busy, new word taken only after completion
        tag = "R8";
        step(1, 32'h0000_002D, 6'd6, 0);
        for (int i = 0; i < 20; i++) step(1, 32'h0000_0F0F, 6'd12, i[0]);
        while (q.size() != 0) step(0, 32'h0, 6'd0, 0);
        tag = "R9"; idle(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule